// File: doc/BRIEF.md
# Bus DMA Cycle Sequencer

This block turns one programmed DMA transfer into a series of bus-cycle requests for a master on a VME-style backplane. Software supplies a start address, a byte count, an address space, a data-width mode and an address-modifier code, then pulses `start`. The sequencer presents one cycle at a time: an address, a transfer size in bytes, the modifier code and two flags. One flag marks a block-transfer beat and the other marks the first beat of a burst. It advances only when the bus side acknowledges the current cycle.

Unaligned starts and ragged ends are covered with byte and double-byte cycles. Full-width cycles are used only while the address is aligned and enough bytes remain. In the block-transfer modes, consecutive full-width beats share one request strobe. The strobe is dropped for one cycle, and a new burst begins, whenever the next beat would start on a 256-byte boundary, or on a 2 KB boundary in the 64-bit mode. Arbitration, data movement, buffering and the electrical signalling of the bus are left to surrounding logic.

Top module: `dma_cycle_seq`

## Requirements
- R1: A start with a zero byte count issues no cycle. `done` is high for exactly one cycle, the cycle after the start edge.
- R2: `space_sel` selects the address width: 0 gives 16 bits, 1 gives 24 bits, and 2 or 3 give 32 bits. Every emitted address has all bits above that width at zero. The address counter wraps within the space.
- R3: `width_sel` selects the full width. 0 is 16-bit single, 1 is 32-bit single, 2 is 16-bit block, 3 is 32-bit block and 4 is 64-bit block. Codes 5 to 7 behave as 16-bit single. The full width is 2, 4 or 8 bytes, and a cycle of that size is issued only when the address is aligned to it and at least that many bytes remain.
- R4: Head alignment: at an odd address the cycle size is 1. At an even address that is not aligned to the full width, the size is 2. `cyc_size` is coded in bytes (1, 2, 4 or 8).
- R5: Tail: when fewer bytes remain than the full width, double-byte cycles are issued while at least 2 bytes remain, then a byte cycle for a final odd byte.
- R6: Each acknowledged cycle advances the address and reduces the remaining count by its size. Cycle addresses are contiguous, and the sizes sum to the byte count.
- R7: The modifier code latched at start appears on every cycle of the transfer.
- R8: In block modes (2, 3, 4), full-width cycles carry `cyc_blt`. A burst keeps `cyc_req` high from beat to beat, and only its first beat carries `cyc_bstart`.
- R9: A burst ends when the next beat address is a multiple of 256 (modes 2 and 3) or 2048 (mode 4). `cyc_req` then goes low for one cycle, and the next beat starts a new burst with `cyc_bstart`.
- R10: Every cycle that does not continue a burst is preceded by exactly one cycle with `cyc_req` low. This applies to all cycles in the single modes and to the head and tail cycles in the block modes. The first cycle appears the cycle after the start edge.
- R11: `done` is high for one cycle, the cycle after the final acknowledge, with `cyc_req` low. `busy` is high from the start edge until then.
- R12: `start` is ignored while a transfer is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a transfer (sampled when idle) |
| start_addr | input | AW | First byte address |
| byte_count | input | CW | Number of bytes to move |
| space_sel | input | 2 | Address space code |
| width_sel | input | 3 | Data width mode code |
| am_code | input | AMW | Address-modifier code for the transfer |
| cyc_ack | input | 1 | Acknowledge of the current cycle |
| cyc_req | output | 1 | Cycle request / address strobe |
| cyc_addr | output | AW | Cycle address |
| cyc_size | output | 4 | Cycle size in bytes |
| cyc_am | output | AMW | Address-modifier code of the cycle |
| cyc_blt | output | 1 | Cycle is a block-transfer beat |
| cyc_bstart | output | 1 | First beat of a burst |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
Several properties are checked by assertions on every cycle:
- every requested cycle is naturally aligned to its size, fits in the remaining count and stays inside the selected address space;
- the modifier code is steady while a request is held;
- a beat that reaches a burst boundary, or any non-burst cycle that is not the last, is followed by a dropped strobe.

Other properties can only be shown by the bench's scenarios:
- the exact sequence of sizes through head, body and tail;
- the contiguity of addresses, including wrap in the 16- and 24-bit spaces;
- the placement of burst-start marks;
- the timing of the completion pulse;
- the ignoring of a start issued mid-transfer.

// File: rtl/dma_cycle_seq.sv
module dma_cycle_seq #(
  parameter int AW  = 32,
  parameter int CW  = 16,
  parameter int AMW = 6
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [AW-1:0]  start_addr,
  input  logic [CW-1:0]  byte_count,
  input  logic [1:0]     space_sel,
  input  logic [2:0]     width_sel,
  input  logic [AMW-1:0] am_code,
  input  logic           cyc_ack,
  output logic           cyc_req,
  output logic [AW-1:0]  cyc_addr,
  output logic [3:0]     cyc_size,
  output logic [AMW-1:0] cyc_am,
  output logic           cyc_blt,
  output logic           cyc_bstart,
  output logic           busy,
  output logic           done
);

  typedef enum logic [1:0] {S_IDLE, S_CYC, S_GAP} st_t;

  localparam logic [AW-1:0] BOUND_SHORT = AW'(255);
  localparam logic [AW-1:0] BOUND_LONG  = AW'(2047);

  function automatic logic [3:0] width_bytes(input logic [2:0] m);
    case (m)
      3'd1, 3'd3: width_bytes = 4'd4;
      3'd4:       width_bytes = 4'd8;
      default:    width_bytes = 4'd2;
    endcase
  endfunction

  function automatic logic [AW-1:0] space_mask(input logic [1:0] s);
    case (s)
      2'd0:    space_mask = AW'(32'h0000_FFFF);
      2'd1:    space_mask = AW'(32'h00FF_FFFF);
      default: space_mask = '1;
    endcase
  endfunction

  st_t            st;
  logic [AW-1:0]  addr_q;
  logic [CW-1:0]  rem_q;
  logic [2:0]     mode_q;
  logic [1:0]     space_q;
  logic [AMW-1:0] am_q;
  logic           cont_q;
  logic           done_q;
  logic [3:0]     size;

  wire [3:0]    fw       = width_bytes(mode_q);
  wire          blt_mode = (mode_q == 3'd2) || (mode_q == 3'd3) || (mode_q == 3'd4);
  wire [AW-1:0] amask    = space_mask(space_q);
  wire [AW-1:0] bmask    = (mode_q == 3'd4) ? BOUND_LONG : BOUND_SHORT;
  wire          aligned  = (addr_q & AW'(fw - 4'd1)) == '0;

  always_comb begin
    if (addr_q[0] || rem_q == CW'(1))        size = 4'd1;
    else if (aligned && rem_q >= CW'(fw))    size = fw;
    else                                     size = 4'd2;
  end

  wire          beat_blt = blt_mode && (size == fw);
  wire [AW-1:0] nxt_addr = (addr_q + AW'(size)) & amask;
  wire [CW-1:0] nxt_rem  = rem_q - CW'(size);
  wire          stay     = beat_blt && (nxt_rem >= CW'(fw)) && ((nxt_addr & bmask) != '0);

  assign cyc_req    = (st == S_CYC);
  assign cyc_addr   = addr_q;
  assign cyc_size   = size;
  assign cyc_am     = am_q;
  assign cyc_blt    = cyc_req && beat_blt;
  assign cyc_bstart = cyc_req && beat_blt && !cont_q;
  assign busy       = (st != S_IDLE);
  assign done       = done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      addr_q  <= '0;
      rem_q   <= '0;
      mode_q  <= '0;
      space_q <= '0;
      am_q    <= '0;
      cont_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          addr_q  <= start_addr & space_mask(space_sel);
          rem_q   <= byte_count;
          mode_q  <= width_sel;
          space_q <= space_sel;
          am_q    <= am_code;
          cont_q  <= 1'b0;
          if (byte_count == '0) done_q <= 1'b1;
          else                  st     <= S_CYC;
        end
        S_CYC: if (cyc_ack) begin
          addr_q <= nxt_addr;
          rem_q  <= nxt_rem;
          cont_q <= stay;
          if (nxt_rem == '0) begin
            st     <= S_IDLE;
            done_q <= 1'b1;
          end else if (!stay) begin
            st <= S_GAP;
          end
        end
        S_GAP:   st <= S_CYC;
        default: st <= S_IDLE;
      endcase
    end
  end

  assert_boundary_break_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_req && cyc_ack && cyc_blt && nxt_rem != '0 && (nxt_addr & bmask) == '0) |=> !cyc_req);

  assert_single_gap_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_req && cyc_ack && !cyc_blt && nxt_rem != '0) |=> !cyc_req);

  assert_size_aligned_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_req |-> ((cyc_addr & AW'(cyc_size - 4'd1)) == '0));

  assert_size_fits_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_req |-> (CW'(cyc_size) <= rem_q));

  assert_addr_in_space_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_req |-> ((cyc_addr & ~amask) == '0));

  assert_am_steady_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_req && $past(cyc_req)) |-> $stable(cyc_am));

  assert_done_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !cyc_req);

  assert_bstart_blt_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_bstart |-> (cyc_blt && cyc_req));

endmodule

// File: tb/test_dma_cycle_seq.sv
`timescale 1ns/1ps
module test_dma_cycle_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] start_addr = '0;
  logic [15:0] byte_count = '0;
  logic [1:0]  space_sel = '0;
  logic [2:0]  width_sel = '0;
  logic [5:0]  am_code = '0;
  logic        cyc_ack = 1'b0;
  logic        cyc_req, cyc_blt, cyc_bstart, busy, done;
  logic [31:0] cyc_addr;
  logic [3:0]  cyc_size;
  logic [5:0]  cyc_am;
  int errs = 0;
  int checks = 0;

  always #2 clk = ~clk;

  dma_cycle_seq i_dma_cycle_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
    .byte_count(byte_count), .space_sel(space_sel), .width_sel(width_sel),
    .am_code(am_code), .cyc_ack(cyc_ack), .cyc_req(cyc_req), .cyc_addr(cyc_addr),
    .cyc_size(cyc_size), .cyc_am(cyc_am), .cyc_blt(cyc_blt), .cyc_bstart(cyc_bstart),
    .busy(busy), .done(done));

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int f_fw(input logic [2:0] m);
    if (m == 3'd1 || m == 3'd3) return 4;
    if (m == 3'd4) return 8;
    return 2;
  endfunction

  function automatic logic [31:0] f_amask(input logic [1:0] s);
    if (s == 2'd0) return 32'h0000_FFFF;
    if (s == 2'd1) return 32'h00FF_FFFF;
    return 32'hFFFF_FFFF;
  endfunction

  function automatic logic [31:0] f_bmask(input logic [2:0] m);
    return (m == 3'd4) ? 32'd2047 : 32'd255;
  endfunction

  function automatic int f_size(input logic [31:0] a, input int r, input logic [2:0] m);
    int w = f_fw(m);
    if (a[0] || r == 1) return 1;
    if ((a % w) == 0 && r >= w) return w;
    return 2;
  endfunction

  task automatic run(input logic [31:0] a, input int cnt, input logic [1:0] sp,
                     input logic [2:0] md, input logic [5:0] am, input bit poke);
    logic [31:0] ea, nxt;
    int er, waited, expw, sz, w;
    bit econt, first, eblt;
    string tag;
    @(negedge clk);
    start_addr = a; byte_count = 16'(cnt); space_sel = sp; width_sel = md; am_code = am;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (cnt == 0) begin
      chk(done && !cyc_req, "R1", "zero count done/req", {done, cyc_req}, 2'b10);
      @(negedge clk);
      chk(!done && !cyc_req && !busy, "R1", "zero count after pulse", {done, cyc_req, busy}, 0);
      return;
    end
    w = f_fw(md);
    ea = a & f_amask(sp); er = cnt; econt = 0; first = 1;
    while (er > 0) begin
      waited = 0;
      while (!cyc_req && waited < 50) begin waited++; @(negedge clk); end
      expw = (first || econt) ? 0 : 1;
      chk(waited == expw, "R10", "idle cycles before cycle", waited, expw);
      sz = f_size(ea, er, md);
      eblt = (md >= 3'd2 && md <= 3'd4) && sz == w;
      tag = (sz == w) ? "R3" : ((er < w) ? "R5" : "R4");
      chk(cyc_addr == ea, (sp == 2'd2) ? "R6" : "R2", "address", cyc_addr, ea);
      chk(cyc_size == 4'(sz), tag, "size", cyc_size, sz);
      chk(cyc_am == am, "R7", "modifier", cyc_am, am);
      chk(cyc_blt == eblt, "R8", "block flag", cyc_blt, eblt);
      chk(cyc_bstart == (eblt && !econt), "R9", "burst start", cyc_bstart, eblt && !econt);
      repeat ($urandom % 3) @(negedge clk);
      cyc_ack = 1'b1;
      if (poke && er > sz) begin
        start = 1'b1; start_addr = 32'hDEAD_0001; byte_count = 16'd0;
      end
      @(negedge clk);
      cyc_ack = 1'b0;
      start = 1'b0;
      nxt = (ea + 32'(sz)) & f_amask(sp);
      er -= sz;
      if (poke && er > 0) chk(!done && busy, "R12", "start ignored while busy", {done, busy}, 2'b01);
      econt = eblt && er >= w && (nxt & f_bmask(md)) != 0;
      ea = nxt; first = 0;
    end
    chk(done && !cyc_req, "R11", "done after final ack", {done, cyc_req}, 2'b10);
    @(negedge clk);
    chk(!done && !busy, "R11", "done single pulse", {done, busy}, 0);
  endtask

  initial begin
    #(4 * 190000);
    errs++; checks++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd7));
    repeat (3) @(negedge clk);
    chk(!cyc_req && !done && !busy, "R11", "reset state", {cyc_req, done, busy}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!cyc_req && !done && !busy, "R11", "idle after reset", {cyc_req, done, busy}, 0);
    run(32'h0000_0040, 0, 2'd2, 3'd1, 6'h0D, 0);
    run(32'h0000_1001, 11, 2'd2, 3'd1, 6'h09, 0);
    run(32'h0000_0003, 5, 2'd2, 3'd0, 6'h39, 0);
    run(32'h0000_07F3, 40, 2'd2, 3'd4, 6'h0B, 0);
    run(32'h0000_00F0, 48, 2'd2, 3'd3, 6'h0F, 0);
    run(32'h0000_00FE, 8, 2'd2, 3'd2, 6'h3F, 0);
    run(32'h1234_FFFA, 12, 2'd0, 3'd1, 6'h29, 0);
    run(32'h7FFF_FFFC, 8, 2'd1, 3'd4, 6'h3B, 1);
    run(32'h0000_0101, 7, 2'd2, 3'd7, 6'h11, 1);
    for (int i = 0; i < 60; i++)
      run($urandom, $urandom % 300, 2'($urandom % 3), 3'($urandom % 5),
          6'($urandom), ($urandom % 4) == 0);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule